// File: doc/BRIEF.md
# Two-Bus Processor Datapath

This block is the processing unit of a small stored-program computer. It holds an instruction register, a memory address register, a program counter, two general registers (X and Y), an operand register (Z) in front of the ALU, the ALU itself and a four-bit condition code register. An external controller sequences the unit. On every clock it chooses the source of each of two buses, asserts load strobes for the registers that should capture a value, may ask the program counter to step, and selects an ALU operation.

The first bus carries the program counter or one of the general registers. It is also the write data presented to memory. The second bus carries the ALU result, the first bus or the memory read data, and it is the only load path into the instruction, address, program counter, general and operand registers. The ALU combines Z with whatever general register sits on the first bus. The controller sees the instruction register as the opcode and reads the NZVC flags to decide its next state.

Top module: `two_bus_datapath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active low), PC, MAR, IR, X, Y and Z become 0 and all four flags are cleared.
- R2: `b1_sel` picks the first bus combinationally: 0 = PC, 1 = X, 2 = Y, 3 = all zeros. `mem_wdata` always equals the first bus.
- R3: `b2_sel` picks the second bus: 0 = ALU result, 1 = first bus, 2 = `mem_rdata`, 3 = all zeros. The second bus is the data input of IR, MAR, PC, X, Y and Z.
- R4: Each of IR, MAR, X, Y and Z captures the second bus on a rising edge where its own load strobe is high. The value is visible right after that edge. With the strobe low the register keeps its value.
- R5: With `pc_inc` high and `pc_ld` low, PC advances by one modulo 256. When both are high, the bus load wins.
- R6: `opcode` shows IR and `mem_addr` shows MAR.
- R7: The ALU's first operand is Z and its second is the first bus. `alu_op` encodes 0 = add, 1 = subtract (Z minus bus), 2 = bitwise AND, 3 = bitwise OR. The result is 8 bits, modulo 256.
- R8: `flags` bit 3 = N (result bit 7), bit 2 = Z (result zero), bit 1 = V, bit 0 = C. The flags are loaded from the ALU of that same cycle only on an edge with `ccr_ld` high, and hold otherwise.
- R9: For add, C is the carry out and V is two's-complement overflow. For subtract, C is 1 when no borrow occurs (Z >= bus, unsigned) and V is signed overflow. AND and OR clear both V and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| b1_sel | input | 2 | First bus source select |
| b2_sel | input | 2 | Second bus source select |
| ir_ld | input | 1 | Instruction register load strobe |
| mar_ld | input | 1 | Memory address register load strobe |
| pc_ld | input | 1 | Program counter load strobe |
| pc_inc | input | 1 | Program counter increment strobe |
| x_ld | input | 1 | X register load strobe |
| y_ld | input | 1 | Y register load strobe |
| z_ld | input | 1 | ALU operand register load strobe |
| ccr_ld | input | 1 | Condition code register load strobe |
| alu_op | input | 2 | ALU operation select |
| mem_rdata | input | 8 | Data read from memory |
| opcode | output | 8 | Instruction register contents to controller |
| flags | output | 4 | Condition codes {N,Z,V,C} |
| mem_addr | output | 8 | Memory address register contents |
| mem_wdata | output | 8 | First bus, data to write to memory |

## Verification
The properties assume the controller holds every select and strobe at a known 0 or 1 level from the first clock onward, including the reset cycles. They make no claim about which combinations of strobes make sense. A simultaneous bus load and increment of PC is legal and is covered by the priority rule. The bench drives all controls from a cleared state before reset is released. It changes inputs only just after a rising edge. Registers are only observed at the ports, by routing X, Y or PC onto the first bus and reading `mem_wdata`, or through `opcode`, `mem_addr` and `flags`.

// File: rtl/dp_pkg.sv
package dp_pkg;

    localparam int DP_W   = 8;
    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        B1_PC   = 2'd0,
        B1_X    = 2'd1,
        B1_Y    = 2'd2,
        B1_NONE = 2'd3
    } b1_src_e;

    typedef enum logic [1:0] {
        B2_ALU  = 2'd0,
        B2_B1   = 2'd1,
        B2_MEM  = 2'd2,
        B2_NONE = 2'd3
    } b2_src_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic ir;
        logic mar;
        logic pc;
        logic x;
        logic y;
        logic z;
        logic ccr;
    } load_vec_t;

    function automatic logic signed_ovf_add(input logic sa, input logic sb, input logic sr);
        return (sa == sb) && (sr != sa);
    endfunction

    function automatic logic signed_ovf_sub(input logic sa, input logic sb, input logic sr);
        return (sa != sb) && (sr != sa);
    endfunction

endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/dp_pc.sv
module dp_pc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] STEP = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (ld)  q <= d;
        else if (inc) q <= q + STEP;
    end
endmodule

// File: rtl/dp_route.sv
module dp_route
    import dp_pkg::*;
#(
    parameter int W = 8
) (
    input  b1_src_e      b1_src,
    input  b2_src_e      b2_src,
    input  logic [W-1:0] pc_q,
    input  logic [W-1:0] x_q,
    input  logic [W-1:0] y_q,
    input  logic [W-1:0] alu_q,
    input  logic [W-1:0] mem_q,
    output logic [W-1:0] bus1,
    output logic [W-1:0] bus2
);
    always_comb begin
        unique case (b1_src)
            B1_PC:   bus1 = pc_q;
            B1_X:    bus1 = x_q;
            B1_Y:    bus1 = y_q;
            default: bus1 = '0;
        endcase
    end

    always_comb begin
        unique case (b2_src)
            B2_ALU:  bus2 = alu_q;
            B2_B1:   bus2 = bus1;
            B2_MEM:  bus2 = mem_q;
            default: bus2 = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output ccr_t         fl
);
    localparam int MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide = '0;
        res  = '0;
        fl   = '0;
        unique case (op)
            OP_ADD: begin
                wide = {1'b0, a} + {1'b0, b};
                res  = wide[W-1:0];
                fl.c = wide[W];
                fl.v = signed_ovf_add(a[MSB], b[MSB], res[MSB]);
            end
            OP_SUB: begin
                wide = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
                res  = wide[W-1:0];
                fl.c = wide[W];
                fl.v = signed_ovf_sub(a[MSB], b[MSB], res[MSB]);
            end
            OP_AND: res = a & b;
            default: res = a | b;
        endcase
        fl.n = res[MSB];
        fl.z = (res == '0);
    end
endmodule

// File: rtl/two_bus_datapath.sv
module two_bus_datapath
    import dp_pkg::*;
#(
    parameter int W = DP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        b1_sel,
    input  logic [1:0]        b2_sel,
    input  logic              ir_ld,
    input  logic              mar_ld,
    input  logic              pc_ld,
    input  logic              pc_inc,
    input  logic              x_ld,
    input  logic              y_ld,
    input  logic              z_ld,
    input  logic              ccr_ld,
    input  logic [1:0]        alu_op,
    input  logic [W-1:0]      mem_rdata,
    output logic [W-1:0]      opcode,
    output logic [FLAG_W-1:0] flags,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata
);
    localparam int NREG = 2;

    load_vec_t    ld;
    logic [W-1:0] bus1;
    logic [W-1:0] bus2;
    logic [W-1:0] pc_q;
    logic [W-1:0] z_q;
    logic [W-1:0] alu_res;
    ccr_t         alu_fl;
    ccr_t         ccr_q;
    logic [W-1:0] gen_q [NREG];
    logic         gen_ld [NREG];

    always_comb begin
        ld.ir  = ir_ld;
        ld.mar = mar_ld;
        ld.pc  = pc_ld;
        ld.x   = x_ld;
        ld.y   = y_ld;
        ld.z   = z_ld;
        ld.ccr = ccr_ld;
    end

    assign gen_ld[0] = ld.x;
    assign gen_ld[1] = ld.y;

    dp_route #(.W(W)) u_route (
        .b1_src (b1_src_e'(b1_sel)),
        .b2_src (b2_src_e'(b2_sel)),
        .pc_q   (pc_q),
        .x_q    (gen_q[0]),
        .y_q    (gen_q[1]),
        .alu_q  (alu_res),
        .mem_q  (mem_rdata),
        .bus1   (bus1),
        .bus2   (bus2)
    );

    dp_alu #(.W(W)) u_alu (
        .op  (alu_op_e'(alu_op)),
        .a   (z_q),
        .b   (bus1),
        .res (alu_res),
        .fl  (alu_fl)
    );

    dp_pc #(.W(W)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld.pc),
        .inc   (pc_inc),
        .d     (bus2),
        .q     (pc_q)
    );

    dp_reg #(.W(W)) u_ir  (.clk(clk), .rst_n(rst_n), .ld(ld.ir),  .d(bus2), .q(opcode));
    dp_reg #(.W(W)) u_mar (.clk(clk), .rst_n(rst_n), .ld(ld.mar), .d(bus2), .q(mem_addr));
    dp_reg #(.W(W)) u_z   (.clk(clk), .rst_n(rst_n), .ld(ld.z),   .d(bus2), .q(z_q));

    for (genvar gi = 0; gi < NREG; gi++) begin : g_user
        dp_reg #(.W(W)) u_r (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (gen_ld[gi]),
            .d     (bus2),
            .q     (gen_q[gi])
        );
    end

    dp_reg #(.W(FLAG_W)) u_ccr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld.ccr),
        .d     (alu_fl),
        .q     (ccr_q)
    );

    assign flags     = ccr_q;
    assign mem_wdata = bus1;
endmodule

// File: rtl/dp_chk.sv
module dp_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mar_ld,
    input logic         ir_ld,
    input logic         pc_ld,
    input logic         pc_inc,
    input logic         ccr_ld,
    input logic [1:0]   alu_op,
    input logic [W-1:0] bus2,
    input logic [W-1:0] pc_q,
    input logic [W-1:0] alu_res,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] opcode,
    input logic [3:0]   flags
);
    localparam logic [W-1:0] ONE = W'(1);

    // R4
    mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mar_ld |=> $stable(mem_addr));

    // R4
    mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mar_ld |=> mem_addr == $past(bus2));

    // R6
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_ld |=> $stable(opcode));

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !pc_ld) |=> pc_q == $past(pc_q) + ONE);

    // R5
    pc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && pc_ld) |=> pc_q == $past(bus2));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_ld |=> flags[2] == ($past(alu_res) == '0));

    // R8
    ccr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ccr_ld |=> $stable(flags));

    // R9
    logic_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_ld && alu_op[1]) |=> flags[1:0] == 2'b00);
endmodule

bind two_bus_datapath dp_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mar_ld   (mar_ld),
    .ir_ld    (ir_ld),
    .pc_ld    (pc_ld),
    .pc_inc   (pc_inc),
    .ccr_ld   (ccr_ld),
    .alu_op   (alu_op),
    .bus2     (bus2),
    .pc_q     (pc_q),
    .alu_res  (alu_res),
    .mem_addr (mem_addr),
    .opcode   (opcode),
    .flags    (flags)
);

// File: tb/two_bus_datapath_bench.sv
module two_bus_datapath_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] b1_sel = 0, b2_sel = 0, alu_op = 0;
    logic       ir_ld = 0, mar_ld = 0, pc_ld = 0, pc_inc = 0;
    logic       x_ld = 0, y_ld = 0, z_ld = 0, ccr_ld = 0;
    logic [7:0] mem_rdata = 0;
    logic [7:0] opcode, mem_addr, mem_wdata;
    logic [3:0] flags;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    two_bus_datapath u_two_bus_datapath (.*);

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        ir_ld = 0; mar_ld = 0; pc_ld = 0; pc_inc = 0;
        x_ld = 0; y_ld = 0; z_ld = 0; ccr_ld = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        quiet();
    endtask

    // which: 0 X, 1 Y, 2 Z, 3 PC
    task automatic put(input int which, input logic [7:0] v);
        b2_sel = 2; mem_rdata = v;
        x_ld = (which == 0); y_ld = (which == 1);
        z_ld = (which == 2); pc_ld = (which == 3);
        tick();
    endtask

    function automatic logic [7:0] peek(input logic [1:0] src);
        b1_sel = src;
        return 8'hxx;
    endfunction

    task automatic look(input logic [1:0] src, output logic [7:0] v);
        b1_sel = src;
        #1;
        v = mem_wdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 opcode", opcode, 0);
        check("R1 mem_addr", mem_addr, 0);
        check("R1 flags", flags, 0);
        look(0, v); check("R1 pc", v, 0);
        look(1, v); check("R1 x", v, 0);
        look(2, v); check("R1 y", v, 0);
    endtask

    task automatic t_fetch();
        b1_sel = 0; b2_sel = 1; mar_ld = 1;
        tick();
        check("R6 mar<=pc", mem_addr, 0);
        b2_sel = 2; mem_rdata = 8'hA5; ir_ld = 1; pc_inc = 1;
        tick();
        check("R6 opcode", opcode, 8'hA5);
        b1_sel = 0; b2_sel = 1; mar_ld = 1;
        tick();
        check("R5 pc step to mar", mem_addr, 1);
    endtask

    task automatic t_alu(input string tag, input logic [1:0] op,
                         input logic [7:0] zv, input logic [7:0] yv,
                         input logic [7:0] er, input logic [3:0] ef);
        logic [7:0] v;
        put(2, zv);
        put(1, yv);
        b1_sel = 2; b2_sel = 0; alu_op = op; x_ld = 1; ccr_ld = 1;
        tick();
        look(1, v);
        check({tag, " result"}, v, er);
        check({tag, " flags"}, flags, ef);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        logic [3:0] f0;
        logic [7:0] op0, a0, x0;
        op0 = opcode; a0 = mem_addr; f0 = flags;
        look(1, x0);
        b1_sel = 2; b2_sel = 2; mem_rdata = 8'h5A; alu_op = 0;
        tick(); tick();
        check("R4 ir hold", opcode, op0);
        check("R4 mar hold", mem_addr, a0);
        check("R8 flags hold", flags, f0);
        look(1, v); check("R4 x hold", v, x0);
        // ALU result into X without ccr_ld leaves flags alone
        put(2, 8'h00); put(1, 8'h00);
        b1_sel = 2; b2_sel = 0; alu_op = 0; x_ld = 1;
        tick();
        check("R8 no ccr load", flags, f0);
        look(1, v); check("R7 sum written", v, 0);
    endtask

    task automatic t_pc();
        logic [7:0] v;
        b2_sel = 2; mem_rdata = 8'h40; pc_ld = 1; pc_inc = 1;
        tick();
        look(0, v); check("R5 load beats inc", v, 8'h40);
        put(3, 8'hFF);
        pc_inc = 1;
        tick();
        look(0, v); check("R5 wrap", v, 0);
    endtask

    task automatic t_buses();
        logic [7:0] v;
        put(1, 8'h3C);
        look(2, v); check("R2 y on wdata", v, 8'h3C);
        look(3, v); check("R2 sel3 zero", v, 0);
        b1_sel = 2; b2_sel = 1; mar_ld = 1;
        tick();
        check("R3 bus1 via bus2", mem_addr, 8'h3C);
        b2_sel = 3; mem_rdata = 8'hFF; mar_ld = 1;
        tick();
        check("R3 sel3 zero", mem_addr, 0);
        b1_sel = 2; b2_sel = 1; z_ld = 1;
        tick();
        put(1, 8'h01);
        b1_sel = 2; b2_sel = 0; alu_op = 3; mar_ld = 1;
        tick();
        check("R7 z op bus1 to mar", mem_addr, 8'h3D);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1;
        t_reset();
        t_fetch();
        t_alu("R9 add ovf",   2'd0, 8'h7F, 8'h01, 8'h80, 4'b1010);
        t_alu("R9 add carry", 2'd0, 8'hFF, 8'h01, 8'h00, 4'b0101);
        t_alu("R9 sub equal", 2'd1, 8'h10, 8'h10, 8'h00, 4'b0101);
        t_alu("R9 sub borrow",2'd1, 8'h00, 8'h01, 8'hFF, 4'b1000);
        t_alu("R9 sub ovf",   2'd1, 8'h80, 8'h01, 8'h7F, 4'b0011);
        t_alu("R7 and",       2'd2, 8'hF0, 8'h3C, 8'h30, 4'b0000);
        t_alu("R7 or",        2'd3, 8'h80, 8'h01, 8'h81, 4'b1000);
        t_alu("R8 or zero",   2'd3, 8'h00, 8'h00, 8'h00, 4'b0100);
        t_hold();
        t_pc();
        t_buses();
        rst_n = 0;
        tick();
        rst_n = 1;
        check("R1 re-reset mar", mem_addr, 0);
        check("R1 re-reset flags", flags, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule